// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, one frame at a time, whether a received Ethernet frame is kept or discarded. It looks only at the 48-bit destination address, which an upstream parser has already pulled out of the frame. The parser presents that address together with a one-cycle frame-start strobe. One cycle later the block raises a decision strobe and an accept flag.

The filter is configured through a simple write-only register port. It holds eight station-address slots and a mode register.
- Slot 0 always takes part in matching.
- Slots 1 to 7 take part only when their enable flag is set.
- The mode register can make the filter accept every frame, or accept every multicast frame.
- Broadcast frames always get through.

With the mode register at zero, the filter does plain exact-match filtering, which is also its state after reset.

Top module: `rx_daddr_filter`

## Requirements
- R1: After reset, `dec_valid` is low. Every slot address and the mode register are zero, so slots 1 to 7 are inactive and multicast frames are dropped unless they match a slot.
- R2: `dec_valid` is high in the cycle after each cycle in which `frame_sof` is high, and low otherwise. Back-to-back strobes give back-to-back decisions.
- R3: A frame whose address equals an active slot is accepted. The address mapping is as follows:
  - Byte k of the destination is `dst_addr[8k+7:8k]`.
  - The slot's low word (offset 0x54+8·n) holds bytes 0 to 3, with byte 0 in bits 7:0.
  - Bits 15:0 of the slot's high word (offset 0x50+8·n) hold bytes 4 and 5.
- R4: Slots 1 to 7 take part in matching only while bit 31 of their high word is set. Writing zero to the high word disables the slot.
- R5: Slot 0 takes part in matching whatever bit 31 of its high word holds.
- R6: When mode bit 0 is set (mode register at offset 0x38), every frame is accepted.
- R7: When mode bit 16 is set, every multicast frame is accepted. A frame is multicast when `dst_addr[0]` is 1. Without bit 16, a multicast frame needs a slot match.
- R8: The broadcast address (all 48 bits one) is always accepted.
- R9: With mode bit 0 clear, a unicast frame that matches no active slot is dropped. Mode bit 16 does not change this.
- R10: Mode bit 13 has no effect on any decision. Writing the mode register to zero returns the filter to plain exact-match filtering.
- R11: A write to an offset that is neither the mode register nor a slot word changes no decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte offset |
| wr_data | input | 32 | Register write data |
| frame_sof | input | 1 | Frame-start strobe; `dst_addr` is valid in this cycle |
| dst_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| dec_valid | output | 1 | Decision strobe, one cycle after `frame_sof` |
| dec_accept | output | 1 | 1 = keep the frame, 0 = drop it; meaningful while `dec_valid` is high |

## Verification
The hardest case to reach is a slot that holds a matching address but must be ignored. This covers three situations:
- a programmed slot whose enable flag was never set;
- a slot disabled again by a zero write;
- slot 0 left with its flag clear, which must still match.

The stimulus programs the same address patterns into enabled and disabled slots and sends both those addresses and near misses that differ by one byte. It then repeats selected frames under every mode setting, including a rewrite of the mode to zero and writes to unmapped offsets, so that every hidden state change shows up in `dec_accept`.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;
    localparam int unsigned MAC_W       = 48;
    localparam int unsigned WORD_W      = 32;
    localparam int unsigned HI_ADDR_W   = MAC_W - WORD_W;
    localparam int unsigned MODE_OFS    = 'h38;
    localparam int unsigned SLOT_BASE   = 'h50;
    localparam int unsigned SLOT_STRIDE = 8;
    localparam int unsigned LO_OFS      = 4;
    localparam int unsigned EN_BIT      = 31;
    localparam int unsigned RXALL_BIT   = 0;
    localparam int unsigned MCPASS_BIT  = 16;

    typedef struct packed {
        logic             rx_all;
        logic             mc_pass;
    } mode_t;

    typedef struct packed {
        logic             valid;
        logic             accept;
    } decision_t;
endpackage

// File: rtl/dafilt_regs.sv
module dafilt_regs
    import dafilt_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 8,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [WORD_W-1:0]             wr_data,
    output logic [NUM_SLOTS-1:0][MAC_W-1:0] slot_addr,
    output logic [NUM_SLOTS-1:0]          slot_en,
    output mode_t                         mode
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0]                 en_flag;
        logic [NUM_SLOTS-1:0][HI_ADDR_W-1:0]  hi;
        logic [NUM_SLOTS-1:0][WORD_W-1:0]     lo;
        mode_t                                mode;
    } regs_t;

    regs_t st_d, st_q;

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[30:17], wr_data[15:1]};

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(MODE_OFS)) begin
                st_d.mode.rx_all  = wr_data[RXALL_BIT];
                st_d.mode.mc_pass = wr_data[MCPASS_BIT];
            end
            for (int k = 0; k < NUM_SLOTS; k++) begin
                if (wr_addr == ADDR_W'(SLOT_BASE + SLOT_STRIDE * k)) begin
                    st_d.en_flag[k] = wr_data[EN_BIT];
                    st_d.hi[k]      = wr_data[HI_ADDR_W-1:0];
                end
                if (wr_addr == ADDR_W'(SLOT_BASE + SLOT_STRIDE * k + LO_OFS)) begin
                    st_d.lo[k] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode = st_q.mode;

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        assign slot_addr[k] = {st_q.hi[k], st_q.lo[k]};
        if (k == 0) begin : g_always
            assign slot_en[k] = 1'b1;
        end else begin : g_flagged
            assign slot_en[k] = st_q.en_flag[k];
            // R4
            hi_zero_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_addr == ADDR_W'(SLOT_BASE + SLOT_STRIDE * k) && wr_data == '0)
                |=> !slot_en[k]);
        end
    end

    // R11
    no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(slot_addr) && $stable(slot_en) && $stable(mode)));
endmodule

// File: rtl/dafilt_match.sv
module dafilt_match
    import dafilt_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 8
) (
    input  logic [MAC_W-1:0]                dst_addr,
    input  logic [NUM_SLOTS-1:0][MAC_W-1:0] slot_addr,
    input  logic [NUM_SLOTS-1:0]            slot_en,
    output logic [NUM_SLOTS-1:0]            hit
);
    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_cmp
        assign hit[k] = slot_en[k] && (slot_addr[k] == dst_addr);
    end
endmodule

// File: rtl/dafilt_decide.sv
module dafilt_decide
    import dafilt_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_sof,
    input  logic [MAC_W-1:0]     dst_addr,
    input  logic [NUM_SLOTS-1:0] hit,
    input  mode_t                mode,
    output logic                 dec_valid,
    output logic                 dec_accept
);
    decision_t dec_d, dec_q;
    logic is_bcast, is_mcast, any_hit;

    assign is_bcast = &dst_addr;
    assign is_mcast = dst_addr[0];
    assign any_hit  = |hit;

    always_comb begin
        dec_d.valid  = frame_sof;
        dec_d.accept = 1'b0;
        if (frame_sof) begin
            if (mode.rx_all || is_bcast)         dec_d.accept = 1'b1;
            else if (is_mcast && mode.mc_pass)   dec_d.accept = 1'b1;
            else                                 dec_d.accept = any_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign dec_valid  = dec_q.valid;
    assign dec_accept = dec_q.accept;

    // R2
    sof_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sof |=> dec_valid);
    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_sof |=> !dec_valid);
    // R6
    rx_all_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sof && mode.rx_all) |=> dec_accept);
    // R8
    bcast_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sof && is_bcast) |=> dec_accept);
    // R9
    unicast_miss_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sof && !mode.rx_all && !is_mcast && !any_hit) |=> !dec_accept);
endmodule

// File: rtl/rx_daddr_filter.sv
module rx_daddr_filter
    import dafilt_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 8,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              frame_sof,
    input  logic [47:0]       dst_addr,
    output logic              dec_valid,
    output logic              dec_accept
);
    logic [NUM_SLOTS-1:0][MAC_W-1:0] slot_addr;
    logic [NUM_SLOTS-1:0]            slot_en;
    logic [NUM_SLOTS-1:0]            hit;
    mode_t                           mode;

    dafilt_regs #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .slot_addr(slot_addr), .slot_en(slot_en), .mode(mode)
    );

    dafilt_match #(.NUM_SLOTS(NUM_SLOTS)) u_match (
        .dst_addr(dst_addr), .slot_addr(slot_addr), .slot_en(slot_en), .hit(hit)
    );

    dafilt_decide #(.NUM_SLOTS(NUM_SLOTS)) u_decide (
        .clk(clk), .rst_n(rst_n), .frame_sof(frame_sof), .dst_addr(dst_addr),
        .hit(hit), .mode(mode), .dec_valid(dec_valid), .dec_accept(dec_accept)
    );
endmodule

// File: tb/rx_daddr_filter_tb.sv
module rx_daddr_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        frame_sof = 1'b0;
    logic [47:0] dst_addr = '0;
    logic        dec_valid, dec_accept;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    rx_daddr_filter dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_sof(frame_sof), .dst_addr(dst_addr),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    typedef struct packed {
        logic [47:0] dst;
        logic        exp;
        logic [3:0]  tag;
    } vec_t;

    localparam logic [47:0] A_S0  = 48'h1111_2222_3344;
    localparam logic [47:0] A_S1  = 48'hAAAA_BBBB_CC10;
    localparam logic [47:0] A_S2  = 48'h5555_6666_7720;
    localparam logic [47:0] A_S3  = 48'h0000_0000_0101;
    localparam logic [47:0] A_S7  = 48'h0102_0304_0506;
    localparam logic [47:0] A_MC  = 48'h0000_0000_0103;
    localparam logic [47:0] A_UMS = 48'hAAAB_BBBB_CC10;
    localparam logic [47:0] A_BC  = 48'hFFFF_FFFF_FFFF;

    localparam vec_t VECS [9] = '{
        '{A_S0,  1'b1, 4'd5}, '{A_S1, 1'b1, 4'd3}, '{A_S2, 1'b0, 4'd4},
        '{A_S7,  1'b1, 4'd3}, '{A_UMS, 1'b0, 4'd9}, '{A_S3, 1'b1, 4'd3},
        '{A_MC,  1'b0, 4'd7}, '{A_BC, 1'b1, 4'd8}, '{48'h0, 1'b0, 4'd9}
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [47:0] got, input logic [47:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send(input logic [47:0] a, input logic exp, input string tag);
        frame_sof = 1'b1; dst_addr = a;
        @(negedge clk);
        frame_sof = 1'b0;
        chk({tag, " valid"}, {47'b0, dec_valid}, 48'd1);
        chk(tag, {47'b0, dec_accept}, {47'b0, exp});
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid at reset", {47'b0, dec_valid}, 48'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid idle", {47'b0, dec_valid}, 48'd0);
        // R5: slot 0 is zero after reset and always active
        send(48'h0, 1'b1, "R5 zero slot0");
        @(negedge clk);
        chk("R2 valid drops", {47'b0, dec_valid}, 48'd0);
        // slot 0 with enable flag clear stays active
        wr(8'h54, 32'h2222_3344);
        wr(8'h50, 32'h0000_1111);
        // R1: zero slots 1-7 are inactive, mode zero drops unmatched multicast
        send(48'h0, 1'b0, "R1 slots inactive");
        send(A_MC, 1'b0, "R1 mode reset");
        // program slots: 1, 3, 7 enabled; 2 written without enable
        wr(8'h5C, 32'hBBBB_CC10); wr(8'h58, 32'h8000_AAAA);
        wr(8'h64, 32'h6666_7720); wr(8'h60, 32'h0000_5555);
        wr(8'h6C, 32'h0000_0101); wr(8'h68, 32'h8000_0000);
        wr(8'h8C, 32'h0304_0506); wr(8'h88, 32'h8000_0102);
        wr(8'h38, 32'h0000_2000);
        for (int i = 0; i < 9; i++) begin
            send(VECS[i].dst, VECS[i].exp, tag_name(VECS[i].tag));
        end
        // R2: back-to-back strobes
        frame_sof = 1'b1; dst_addr = A_S1;
        @(negedge clk);
        chk("R2 b2b valid 1", {47'b0, dec_valid}, 48'd1);
        chk("R2 b2b accept 1", {47'b0, dec_accept}, 48'd1);
        dst_addr = A_UMS;
        @(negedge clk);
        frame_sof = 1'b0;
        chk("R2 b2b valid 2", {47'b0, dec_valid}, 48'd1);
        chk("R2 b2b accept 2", {47'b0, dec_accept}, 48'd0);
        @(negedge clk);
        chk("R2 b2b end", {47'b0, dec_valid}, 48'd0);
        // R6: receive all
        wr(8'h38, 32'h0000_0001);
        send(48'h7777_8888_9902, 1'b1, "R6 unicast miss");
        send(A_S2, 1'b1, "R6 disabled slot");
        // R7: pass multicast; R9 unicast still filtered
        wr(8'h38, 32'h0001_0000);
        send(A_MC, 1'b1, "R7 multicast pass");
        send(A_UMS, 1'b0, "R9 unicast with mc pass");
        // R10: mode zero behaves as normal filtering
        wr(8'h38, 32'h0000_0000);
        send(A_MC, 1'b0, "R10 mode zero mc");
        send(A_S1, 1'b1, "R10 mode zero match");
        send(A_BC, 1'b1, "R8 broadcast mode zero");
        // R4: zero write disables slot 1
        wr(8'h58, 32'h0000_0000);
        send(A_S1, 1'b0, "R4 slot1 disabled");
        // R11: unmapped offsets
        wr(8'h3C, 32'hFFFF_FFFF);
        wr(8'h90, 32'hFFFF_FFFF);
        wr(8'h4C, 32'hFFFF_FFFF);
        send(A_S2, 1'b0, "R11 slot2 still off");
        send(A_MC, 1'b0, "R11 mode untouched");
        send(A_S7, 1'b1, "R11 slot7 intact");
        done = 1'b1;
        summary();
        $finish;
    end
endmodule